// File: doc/BRIEF.md
# Raw NAND Bus Operation Sequencer

This block turns a stream of typed instruction entries from a host into signal activity on an 8-bit asynchronous raw NAND flash bus. Each entry names one action: send a command byte, send an address byte, write a data byte, read a data byte, or wait for the flash to report ready. The entry that carries the `last` flag closes the operation. Chip enable stays asserted from the first entry of an operation to its end. The block drives the two latch-select lines, the write and read strobes, and the output enable of the data bus. Every byte it reads goes out on a separate valid/ready stream.

Write and read strobe widths are set by two configuration inputs. These give minimum pulse times in picoseconds. The block rounds each value up to whole nanoseconds, then up to whole clock cycles. The data bus direction is changed only when the direction of traffic actually changes, and the bus keeps its direction between operations. A ready wait that runs past its millisecond budget cancels the rest of the operation. The remaining entries are consumed without any bus activity, and the operation ends with its error bit set. The write-protect line is under separate host control.

Top module: `nand_op_sequencer`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), both latch selects are low, the data bus is not driven, write protect is low (protected), `busy` is low and `rd_valid` is low.
- R2: Chip enable falls once when an operation starts, before its first strobe. It stays low through every entry of the operation and rises once after the last entry. Strobes occur only while chip enable is low.
- R3: A command entry (type 3'd0) raises the command latch select, writes its byte with exactly one write strobe, and lowers the select again. Two command entries in a row give two separate select pulses.
- R4: Consecutive address entries (type 3'd1) share one high window of the address latch select, with one write strobe per byte in arrival order. The select falls when the next entry is of another type or when the operation ends.
- R5: A data-out entry (type 3'd2) writes its byte with both latch selects low. During every write strobe the bus is driven and the byte on it is stable. The strobe is low for exactly the programmed write cycle count.
- R6: A data-in entry (type 3'd3) pulls the read strobe low for exactly the programmed read cycle count and samples the bus in the last low cycle. The byte is offered on `rd_data` with `rd_valid`, and both are held until `rd_ready` accepts them.
- R7: Each strobe cycle count equals ceil(ceil(ps / 1000) / CLK_NS), with a minimum of 1.
- R8: The data bus is driven from the first write after reset or after a read, and released at the first read after a write. Its direction persists across operations, and entries that are skipped do not change it.
- R9: A wait entry (type 3'd4, byte = timeout in ms) finishes without error as soon as `bus_ready` is high, including when ready arrives partway through the wait.
- R10: If `bus_ready` stays low for the timeout (byte × CYC_PER_MS cycles, so 0 ms times out at once), the remaining entries up to the last one are consumed with no strobe, chip enable is released, and `done_err` is 1.
- R11: `bus_wprot_n` is low out of reset. `wp_release` raises it, and `wp_engage` lowers it. If both pulse in the same cycle, `wp_engage` wins.
- R12: After either latch select falls, at least one cycle with both strobes inactive passes before the next strobe.
- R13: `busy` is high from the start of an operation until it completes. `done` is a single-cycle pulse at the end, and `done_err` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_pulse_ps | input | PS_W | Minimum write strobe width in ps |
| cfg_rd_pulse_ps | input | PS_W | Minimum read strobe width in ps |
| wp_release | input | 1 | Pulse: lift write protection |
| wp_engage | input | 1 | Pulse: apply write protection |
| ins_valid | input | 1 | Instruction entry valid |
| ins_ready | output | 1 | Instruction entry accepted when high with valid |
| ins_type | input | 3 | 0 cmd, 1 addr, 2 data out, 3 data in, 4 wait |
| ins_byte | input | DATA_W | Byte to write, or timeout in ms for a wait |
| ins_last | input | 1 | Entry closes the operation |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer accepts the read byte |
| rd_data | output | DATA_W | Read byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Operation ended by ready timeout (valid with done) |
| bus_chip_en_n | output | 1 | Flash chip enable, active low |
| bus_cmd_latch | output | 1 | Command latch select |
| bus_addr_latch | output | 1 | Address latch select |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wprot_n | output | 1 | Write protect, active low |
| bus_dq_out | output | DATA_W | Data bus value when driven |
| bus_dq_drive | output | 1 | Data bus output enable |
| bus_dq_in | input | DATA_W | Data bus value from the flash |
| bus_ready | input | 1 | Flash ready (1) / busy (0) |

## Verification
The hardest state to reach is the timeout abort. The flash has to stay busy through a whole millisecond budget while entries of every kind are still queued behind the wait. The bench builds the block with a short millisecond and holds `bus_ready` low during a wait. It then feeds a data-out, a data-in and a final command entry, and the scoreboard fails on any strobe it did not expect. Because the skipped read must not turn the bus around, the bench also checks that the bus is still driven afterwards. Backpressure on the read stream is reached by holding `rd_ready` low while a second data-in entry waits behind the first.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        INS_CMD  = 3'd0,
        INS_ADDR = 3'd1,
        INS_DOUT = 3'd2,
        INS_DIN  = 3'd3,
        INS_WAIT = 3'd4
    } ins_kind_e;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_FETCH  = 4'd1,
        S_HOLD   = 4'd2,
        S_EXEC   = 4'd3,
        S_WSETUP = 4'd4,
        S_WPULSE = 4'd5,
        S_WREL   = 4'd6,
        S_RPULSE = 4'd7,
        S_RPUSH  = 4'd8,
        S_WAITRB = 4'd9,
        S_DRAIN  = 4'd10,
        S_CLOSE  = 4'd11
    } seq_state_e;

endpackage

// File: rtl/nand_strobe_cycles.sv
// Converts a minimum pulse time in picoseconds into a clock cycle count:
// round up to whole nanoseconds, then up to whole cycles, never below one.
module nand_strobe_cycles #(
    parameter int PS_W   = 16,
    parameter int CYC_W  = 8,
    parameter int CLK_NS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PS_W-1:0]  pulse_ps,
    output logic [CYC_W-1:0] cycles
);
    localparam int EXT_W = PS_W + 1;
    localparam logic [EXT_W-1:0] CYC_MAX = EXT_W'((1 << CYC_W) - 1);

    logic [EXT_W-1:0] ns_v, cyc_full;
    logic [CYC_W-1:0] cyc_d, cyc_q;

    always_comb begin
        ns_v     = ({1'b0, pulse_ps} + EXT_W'(999)) / EXT_W'(1000);
        cyc_full = (ns_v + EXT_W'(CLK_NS - 1)) / EXT_W'(CLK_NS);
        if (cyc_full == '0)
            cyc_d = CYC_W'(1);
        else if (cyc_full > CYC_MAX)
            cyc_d = CYC_MAX[CYC_W-1:0];
        else
            cyc_d = cyc_full[CYC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= CYC_W'(1);
        else        cyc_q <= cyc_d;
    end

    assign cycles = cyc_q;

    // R7: a strobe is never programmed shorter than one cycle
    assert_width_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q != '0);

endmodule

// File: rtl/nand_ready_timer.sv
// Millisecond budget for a ready wait: loaded with a count of ms, counts
// down while running, reports expiry when the budget reaches zero.
module nand_ready_timer #(
    parameter int MS_W       = 8,
    parameter int CYC_PER_MS = 50000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] ms_in,
    input  logic            run,
    output logic            expired
);
    localparam int SUB_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CYC_PER_MS - 1);

    typedef struct packed {
        logic [MS_W-1:0]  ms;
        logic [SUB_W-1:0] sub;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.ms  = ms_in;
            tmr_d.sub = '0;
        end else if (run && tmr_q.ms != '0) begin
            if (tmr_q.sub == SUB_LAST) begin
                tmr_d.sub = '0;
                tmr_d.ms  = tmr_q.ms - MS_W'(1);
            end else begin
                tmr_d.sub = tmr_q.sub + SUB_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = (tmr_q.ms == '0);

    // R10: once the budget has run out it stays out until reloaded
    assert_expiry_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
    import nand_seq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PS_W       = 16,
    parameter int CYC_W      = 8,
    parameter int CLK_NS     = 20,
    parameter int CYC_PER_MS = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PS_W-1:0]   cfg_wr_pulse_ps,
    input  logic [PS_W-1:0]   cfg_rd_pulse_ps,
    input  logic              wp_release,
    input  logic              wp_engage,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [2:0]        ins_type,
    input  logic [DATA_W-1:0] ins_byte,
    input  logic              ins_last,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    output logic              bus_chip_en_n,
    output logic              bus_cmd_latch,
    output logic              bus_addr_latch,
    output logic              bus_wr_n,
    output logic              bus_rd_n,
    output logic              bus_wprot_n,
    output logic [DATA_W-1:0] bus_dq_out,
    output logic              bus_dq_drive,
    input  logic [DATA_W-1:0] bus_dq_in,
    input  logic              bus_ready
);

    typedef struct packed {
        seq_state_e        st;
        logic              ce_n;
        logic              cle;
        logic              ale;
        logic              we_n;
        logic              re_n;
        logic              wp_n;
        logic [DATA_W-1:0] dq;
        logic              oe;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              derr;
        logic              err;
        logic [CYC_W-1:0]  cnt;
        logic [2:0]        kind;
        logic [DATA_W-1:0] val;
        logic              last;
    } seq_t;

    seq_t q, d;

    logic [CYC_W-1:0] wr_cycles, rd_cycles;
    logic             tmr_load, tmr_run, tmr_expired;
    logic             fin;

    nand_strobe_cycles #(.PS_W(PS_W), .CYC_W(CYC_W), .CLK_NS(CLK_NS)) u_wr_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_ps (cfg_wr_pulse_ps),
        .cycles   (wr_cycles)
    );

    nand_strobe_cycles #(.PS_W(PS_W), .CYC_W(CYC_W), .CLK_NS(CLK_NS)) u_rd_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_ps (cfg_rd_pulse_ps),
        .cycles   (rd_cycles)
    );

    assign tmr_load = (q.st == S_EXEC) && (q.kind == INS_WAIT);
    assign tmr_run  = (q.st == S_WAITRB);

    nand_ready_timer #(.MS_W(DATA_W), .CYC_PER_MS(CYC_PER_MS)) u_rb_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .ms_in   (q.val),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        fin    = 1'b0;

        // write protect: engage has priority over release
        if (wp_engage)       d.wp_n = 1'b0;
        else if (wp_release) d.wp_n = 1'b1;

        unique case (q.st)
            S_IDLE: begin
                if (ins_valid) begin
                    d.ce_n = 1'b0;
                    d.st   = S_FETCH;
                end
            end
            S_FETCH: begin
                if (ins_valid) begin
                    d.kind = ins_type;
                    d.val  = ins_byte;
                    d.last = ins_last;
                    if (q.ale && ins_type != INS_ADDR) begin
                        d.ale = 1'b0;
                        d.st  = S_HOLD;
                    end else begin
                        d.st  = S_EXEC;
                    end
                end
            end
            S_HOLD: d.st = S_EXEC;
            S_EXEC: begin
                case (q.kind)
                    INS_CMD, INS_ADDR, INS_DOUT: begin
                        d.dq  = q.val;
                        d.oe  = 1'b1;
                        d.cle = (q.kind == INS_CMD);
                        d.ale = (q.kind == INS_ADDR);
                        d.st  = S_WSETUP;
                    end
                    INS_DIN: begin
                        if (q.oe) begin
                            d.oe = 1'b0;          // turnaround cycle
                        end else begin
                            d.re_n = 1'b0;
                            d.cnt  = CYC_W'(1);
                            d.st   = S_RPULSE;
                        end
                    end
                    INS_WAIT: d.st = S_WAITRB;
                    default:  fin  = 1'b1;         // unused type: no bus action
                endcase
            end
            S_WSETUP: begin
                d.we_n = 1'b0;
                d.cnt  = CYC_W'(1);
                d.st   = S_WPULSE;
            end
            S_WPULSE: begin
                if (q.cnt >= wr_cycles) begin
                    d.we_n = 1'b1;
                    d.st   = S_WREL;
                end else begin
                    d.cnt = q.cnt + CYC_W'(1);
                end
            end
            S_WREL: begin
                if (q.kind == INS_CMD) d.cle = 1'b0;
                fin = 1'b1;
            end
            S_RPULSE: begin
                if (q.cnt >= rd_cycles) begin
                    d.re_n   = 1'b1;
                    d.rdata  = bus_dq_in;
                    d.rvalid = 1'b1;
                    d.st     = S_RPUSH;
                end else begin
                    d.cnt = q.cnt + CYC_W'(1);
                end
            end
            S_RPUSH: begin
                if (rd_ready) begin
                    d.rvalid = 1'b0;
                    fin      = 1'b1;
                end
            end
            S_WAITRB: begin
                if (bus_ready) begin
                    fin = 1'b1;
                end else if (tmr_expired) begin
                    d.err = 1'b1;
                    d.st  = q.last ? S_CLOSE : S_DRAIN;
                end
            end
            S_DRAIN: begin
                if (ins_valid && ins_last) d.st = S_CLOSE;
            end
            S_CLOSE: begin
                d.ale  = 1'b0;
                d.cle  = 1'b0;
                d.ce_n = 1'b1;
                d.done = 1'b1;
                d.derr = q.err;
                d.err  = 1'b0;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        if (fin) begin
            if (q.last) begin
                d.ale = 1'b0;
                d.cle = 1'b0;
                d.st  = S_CLOSE;
            end else begin
                d.st  = S_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.ce_n <= 1'b1;
            q.we_n <= 1'b1;
            q.re_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ins_ready      = (q.st == S_FETCH) || (q.st == S_DRAIN);
    assign rd_valid       = q.rvalid;
    assign rd_data        = q.rdata;
    assign busy           = (q.st != S_IDLE);
    assign done           = q.done;
    assign done_err       = q.derr;
    assign bus_chip_en_n  = q.ce_n;
    assign bus_cmd_latch  = q.cle;
    assign bus_addr_latch = q.ale;
    assign bus_wr_n       = q.we_n;
    assign bus_rd_n       = q.re_n;
    assign bus_wprot_n    = q.wp_n;
    assign bus_dq_out     = q.dq;
    assign bus_dq_drive   = q.oe;

    // R2: no strobe outside the chip-enable window
    assert_wr_under_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> !bus_chip_en_n);
    assert_rd_under_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_chip_en_n);

    // R3/R4: the two latch selects are never high together
    assert_latch_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cmd_latch && bus_addr_latch));

    // R5: bus driven and stable across a write strobe
    assert_wr_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> (bus_dq_drive && $stable(bus_dq_out)));

    // R8: the block never drives against the flash during a read
    assert_rd_bus_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_dq_drive);

    // R6: read byte held under backpressure
    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R10: skipped entries cause no strobe
    assert_drain_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DRAIN) |-> (bus_wr_n && bus_rd_n));

    // R11: engage request always lands
    assert_wp_engage_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wp_engage |=> !bus_wprot_n);

    // R12: idle gap after a latch select falls
    assert_cle_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cmd_latch) |-> (bus_wr_n && bus_rd_n));
    assert_ale_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_addr_latch) |-> (bus_wr_n && bus_rd_n));

    // R13: completion is a single-cycle pulse
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_nand_op_sequencer.sv
module test_nand_op_sequencer;
    localparam int CLK_NS = 20;
    localparam int CPM    = 10;
    localparam logic [2:0] T_CMD = 3'd0, T_ADDR = 3'd1, T_DOUT = 3'd2,
                           T_DIN = 3'd3, T_WAIT = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [15:0] cfg_wr_pulse_ps = 16'd25000;
    logic [15:0] cfg_rd_pulse_ps = 16'd41001;
    logic wp_release = 0, wp_engage = 0;
    logic ins_valid = 0, ins_last = 0;
    logic [2:0] ins_type = 0;
    logic [7:0] ins_byte = 0;
    logic ins_ready, rd_valid, busy, done, done_err;
    logic rd_ready = 1'b1;
    logic [7:0] rd_data, bus_dq_out;
    logic bus_chip_en_n, bus_cmd_latch, bus_addr_latch, bus_wr_n, bus_rd_n;
    logic bus_wprot_n, bus_dq_drive;
    logic bus_ready = 1'b1;
    logic [7:0] model_byte = 8'h3C;
    logic [7:0] bus_dq_in;
    assign bus_dq_in = model_byte;

    nand_op_sequencer #(.CLK_NS(CLK_NS), .CYC_PER_MS(CPM)) i_nand_op_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_pulse_ps(cfg_wr_pulse_ps), .cfg_rd_pulse_ps(cfg_rd_pulse_ps),
        .wp_release(wp_release), .wp_engage(wp_engage),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_type(ins_type),
        .ins_byte(ins_byte), .ins_last(ins_last),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .busy(busy), .done(done), .done_err(done_err),
        .bus_chip_en_n(bus_chip_en_n), .bus_cmd_latch(bus_cmd_latch),
        .bus_addr_latch(bus_addr_latch), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .bus_wprot_n(bus_wprot_n), .bus_dq_out(bus_dq_out),
        .bus_dq_drive(bus_dq_drive), .bus_dq_in(bus_dq_in), .bus_ready(bus_ready)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int cyc_of(input int ps);
        int ns = (ps + 999) / 1000;
        int c  = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    // scoreboard
    logic [9:0] exp_wr[$];
    logic [7:0] exp_rd[$];
    int exp_twp = 2, exp_trp = 3;
    logic [7:0] drv_rd = 8'h3C;

    int we_len = 0, re_len = 0;
    logic [7:0] we_byte;
    logic we_cle, we_ale, we_ce_bad = 0, rd_seen = 0;
    int ce_falls = 0, cle_rises = 0, ale_rises = 0;
    logic p_ce = 1, p_cle = 0, p_ale = 0;
    logic armed = 0;
    int gap = 0;

    always @(negedge clk) if (rst_n) begin
        // write strobe
        if (!bus_wr_n) begin
            we_len++; we_byte = bus_dq_out; we_cle = bus_cmd_latch; we_ale = bus_addr_latch;
            if (bus_chip_en_n) we_ce_bad = 1;
        end else if (we_len > 0) begin
            if (exp_wr.size() == 0) begin
                chk(0, "R10 unexpected write strobe", int'(we_byte), -1);
            end else begin
                logic [9:0] e;
                e = exp_wr.pop_front();
                chk({we_cle, we_ale, we_byte} == e, "R3 R4 R5 strobe latch/byte",
                    int'({we_cle, we_ale, we_byte}), int'(e));
                chk(we_len == exp_twp, "R5 R7 write strobe width", we_len, exp_twp);
            end
            chk(!we_ce_bad, "R2 chip enable low during strobe", int'(we_ce_bad), 0);
            we_len = 0; we_ce_bad = 0;
        end
        // read strobe and flash model
        if (!bus_rd_n) begin
            re_len++;
        end else if (re_len > 0) begin
            chk(re_len == exp_trp, "R6 R7 read strobe width", re_len, exp_trp);
            model_byte = model_byte + 8'h11;
            re_len = 0;
        end
        // read stream
        if (rd_valid && !rd_seen) begin
            rd_seen = 1;
            if (exp_rd.size() == 0) chk(0, "R6 unexpected read byte", int'(rd_data), -1);
            else begin
                logic [7:0] r;
                r = exp_rd.pop_front();
                chk(rd_data == r, "R6 read data", int'(rd_data), int'(r));
            end
        end else if (!rd_valid) rd_seen = 0;
        // edge counts
        if (p_ce && !bus_chip_en_n) ce_falls++;
        if (!p_cle && bus_cmd_latch) cle_rises++;
        if (!p_ale && bus_addr_latch) ale_rises++;
        // R12 gap after a latch select falls
        if ((p_cle && !bus_cmd_latch) || (p_ale && !bus_addr_latch)) begin
            armed = 1; gap = 0;
        end
        if (armed) begin
            if (bus_wr_n && bus_rd_n) gap++;
            else begin
                chk(gap >= 1, "R12 idle gap after latch fall", gap, 1);
                armed = 0;
            end
        end
        p_ce = bus_chip_en_n; p_cle = bus_cmd_latch; p_ale = bus_addr_latch;
    end

    task automatic push(input logic [2:0] t, input logic [7:0] b, input bit l);
        @(negedge clk);
        ins_valid = 1; ins_type = t; ins_byte = b; ins_last = l;
        while (!ins_ready) @(negedge clk);
        @(posedge clk);
        #1 ins_valid = 0;
    endtask

    task automatic wr(input logic [2:0] t, input logic [7:0] b, input bit l);
        exp_wr.push_back({t == T_CMD, t == T_ADDR, b});
        push(t, b, l);
    endtask

    task automatic rd(input bit l);
        exp_rd.push_back(drv_rd);
        drv_rd = drv_rd + 8'h11;
        push(T_DIN, 8'h00, l);
    endtask

    task automatic wait_done(input bit exp_err, input string tag);
        @(negedge clk);
        while (!done) @(negedge clk);
        chk(done_err == exp_err, tag, int'(done_err), int'(exp_err));
        @(negedge clk);
        chk(!done && !busy, "R13 done pulse single cycle, idle after", int'({done, busy}), 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R13 watchdog: run never completed actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int c0, c1, t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_chip_en_n && bus_wr_n && bus_rd_n, "R1 strobes/CE idle in reset",
            int'({bus_chip_en_n, bus_wr_n, bus_rd_n}), 7);
        chk(!bus_cmd_latch && !bus_addr_latch && !bus_dq_drive, "R1 latches low, bus released",
            int'({bus_cmd_latch, bus_addr_latch, bus_dq_drive}), 0);
        chk(!bus_wprot_n && !busy && !rd_valid, "R1 protected, not busy, no read",
            int'({bus_wprot_n, busy, rd_valid}), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        exp_twp = cyc_of(25000); exp_trp = cyc_of(41001);
        chk(exp_twp == 2 && exp_trp == 3, "R7 bench rounding model", exp_twp * 10 + exp_trp, 23);

        // Op A: cmd, three address bytes, two data bytes
        c0 = ce_falls; c1 = cle_rises; t0 = ale_rises;
        wr(T_CMD, 8'h80, 0);
        wr(T_ADDR, 8'h11, 0); wr(T_ADDR, 8'h22, 0); wr(T_ADDR, 8'h33, 0);
        wr(T_DOUT, 8'h5A, 0); wr(T_DOUT, 8'hA5, 1);
        wait_done(0, "R5 program sequence no error");
        chk(ce_falls - c0 == 1, "R2 one CE window", ce_falls - c0, 1);
        chk(cle_rises - c1 == 1, "R3 one CLE pulse", cle_rises - c1, 1);
        chk(ale_rises - t0 == 1, "R4 address bytes share ALE window", ale_rises - t0, 1);
        chk(bus_chip_en_n, "R2 CE released at end", int'(bus_chip_en_n), 1);
        chk(bus_dq_drive, "R8 bus stays driven after write op", int'(bus_dq_drive), 1);

        // Op B: two commands, wait already ready, two reads with backpressure
        rd_ready = 0;
        c1 = cle_rises;
        fork
            begin
                wr(T_CMD, 8'h00, 0); wr(T_CMD, 8'h30, 0);
                push(T_WAIT, 8'd5, 0);
                rd(0); rd(1);
            end
            begin
                logic [7:0] d0;
                @(negedge clk);
                while (!rd_valid) @(negedge clk);
                d0 = rd_data;
                repeat (6) @(negedge clk);
                chk(rd_valid && rd_data == d0, "R6 byte held under backpressure",
                    int'(rd_data), int'(d0));
                #2 rd_ready = 1;
            end
        join
        wait_done(0, "R9 ready wait passes");
        chk(cle_rises - c1 == 2, "R3 separate CLE pulses", cle_rises - c1, 2);
        chk(!bus_dq_drive, "R8 bus released after read op", int'(bus_dq_drive), 0);

        // Op C: timeout aborts remaining entries
        bus_ready = 0;
        wr(T_CMD, 8'h70, 0);
        push(T_WAIT, 8'd2, 0);
        t0 = cyc;
        push(T_DOUT, 8'h99, 0);
        push(T_DIN, 8'h00, 0);
        push(T_CMD, 8'hFF, 1);
        wait_done(1, "R10 timeout reports error");
        chk(cyc - t0 >= 2 * CPM && cyc - t0 <= 45, "R10 timeout duration", cyc - t0, 2 * CPM);
        chk(bus_dq_drive, "R8 R10 skipped read did not turn bus", int'(bus_dq_drive), 1);
        chk(bus_chip_en_n, "R10 CE released after abort", int'(bus_chip_en_n), 1);
        bus_ready = 1;

        // Write protect
        @(negedge clk); wp_release = 1; @(negedge clk); wp_release = 0;
        chk(bus_wprot_n, "R11 release lifts protection", int'(bus_wprot_n), 1);
        @(negedge clk); wp_engage = 1; @(negedge clk); wp_engage = 0;
        chk(!bus_wprot_n, "R11 engage applies protection", int'(bus_wprot_n), 0);
        @(negedge clk); wp_release = 1; wp_engage = 1; @(negedge clk);
        wp_release = 0; wp_engage = 0;
        chk(!bus_wprot_n, "R11 engage wins over release", int'(bus_wprot_n), 0);
        @(negedge clk); wp_release = 1; @(negedge clk); wp_release = 0;

        // Op D: other widths
        cfg_wr_pulse_ps = 16'd40001; cfg_rd_pulse_ps = 16'd0;
        exp_twp = cyc_of(40001); exp_trp = cyc_of(0);
        repeat (3) @(negedge clk);
        wr(T_DOUT, 8'h42, 0); rd(1);
        wait_done(0, "R7 widths 3 and 1 cycles");
        chk(!bus_dq_drive, "R8 released at first read after write", int'(bus_dq_drive), 0);

        // Op E: address then command, one-cycle write strobe
        cfg_wr_pulse_ps = 16'd1; exp_twp = cyc_of(1);
        repeat (3) @(negedge clk);
        c0 = ale_rises; c1 = cle_rises;
        wr(T_ADDR, 8'h01, 0); wr(T_ADDR, 8'h02, 0); wr(T_CMD, 8'h10, 1);
        wait_done(0, "R4 address then command");
        chk(ale_rises - c0 == 1 && cle_rises - c1 == 1, "R4 R3 latch windows",
            (ale_rises - c0) * 10 + cle_rises - c1, 11);
        chk(bus_dq_drive, "R8 driven at first write after read", int'(bus_dq_drive), 1);

        // Op F: ready arrives during the wait
        bus_ready = 0;
        push(T_WAIT, 8'd3, 1);
        repeat (8) @(negedge clk);
        chk(busy && !bus_chip_en_n, "R13 busy during wait", int'({busy, bus_chip_en_n}), 2);
        bus_ready = 1;
        wait_done(0, "R9 ready mid-wait no error");

        // Op G: zero budget times out at once
        bus_ready = 0;
        push(T_WAIT, 8'd0, 1);
        wait_done(1, "R10 zero timeout");
        bus_ready = 1;

        repeat (4) @(negedge clk);
        chk(exp_wr.size() == 0, "R3 R5 all expected writes seen", exp_wr.size(), 0);
        chk(exp_rd.size() == 0, "R6 all expected reads seen", exp_rd.size(), 0);
        summary();
        $finish;
    end
endmodule